// File: doc/BRIEF.md
# Dual-Rail Four-Phase Word Receiver

This block takes in a word that arrives as dual-rail bit pairs and returns an acknowledge. There is no request wire. A new word is announced only by every bit pair leaving the empty code. The validity of each pair is the OR of its two rails. A hysteretic merge stage collects the per-bit validity into one completion flag. That flag sets when all pairs carry data and clears only when all pairs have gone back to the empty code. Between those two points it keeps its previous value.

The acknowledge is the registered completion flag. A full transfer is therefore four events: the sender presents data, the acknowledge rises, the sender returns every pair to empty, and the acknowledge falls. The merge state is kept in a clocked register that samples the rails, so the rails must be stable around each clock edge.

When the flag sets, the block decodes the word and presents it to a local consumer with a one-cycle valid strobe. The output side has no ready input. The sender is held back by the acknowledge, so a new word can arrive no sooner than one return-to-empty phase later, and the consumer must take each strobe when it appears. A pair that shows both rails high is illegal and sets an error flag that stays set until reset.

Top module: `dr_completion_rx`

## Requirements
- R1: Bit i of the word arrives on `rails_i[2i+1:2i]` as {upper, lower}: 00 is empty, 01 is logic 0, 10 is logic 1, and 11 is illegal.
- R2: A pair counts as valid when either of its rails is 1. The completion flag, and with it `ack_o`, is 0 while at least one pair reads empty.
- R3: When a clock edge samples every pair valid while `ack_o` is 0, `ack_o` is 1 after that edge.
- R4: When `ack_o` is 1, it returns to 0 only after an edge that samples every pair as 00.
- R5: While some pairs are valid and others are empty, `ack_o` keeps its previous value.
- R6: On the edge where `ack_o` rises, `word_o` takes the decoded word (bit i equals the upper rail of pair i), and `word_valid_o` is 1 for exactly that one cycle.
- R7: `word_o` does not change between captures, including during the return-to-empty phase.
- R8: Any edge that samples a pair at 11 sets `err_o`. `err_o` stays 1 until reset.
- R9: Reset clears `ack_o`, `word_valid_o`, `err_o` and `word_o` to 0. During reset the rails are expected to read empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rails_i | input | 2*WIDTH | Dual-rail pairs, bit i at [2i+1:2i] |
| ack_o | output | 1 | Four-phase acknowledge to the sender |
| word_o | output | WIDTH | Last decoded word |
| word_valid_o | output | 1 | One-cycle strobe when a new word is captured |
| err_o | output | 1 | Sticky flag for an illegal pair |

## Verification
The hardest case to reach is a word that is only partly valid. In that state the merge must hold its value and not follow any one bit, on the way in and again on the way back to empty. The bench reaches it by staggering the pairs one per clock in both phases. After each step it checks that the acknowledge has not moved, that no extra strobe appears, and that the captured word stays fixed. A separate directed case drives one pair to 11 while the rest are empty. This shows that the error latches and lasts through later clean transfers, and that an illegal pair on its own cannot complete a word.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [1:0] pair_t;
  localparam pair_t PAIR_EMPTY = 2'b00;
  localparam pair_t PAIR_ZERO  = 2'b01;
  localparam pair_t PAIR_ONE   = 2'b10;
  localparam pair_t PAIR_BAD   = 2'b11;
endpackage

// File: rtl/dr_pair_decode.sv
module dr_pair_decode #(
  parameter int WIDTH = 8
) (
  input  logic [2*WIDTH-1:0] rails_i,
  output logic [WIDTH-1:0]   vld_o,
  output logic [WIDTH-1:0]   bit_o,
  output logic [WIDTH-1:0]   bad_o
);
  import dr_pkg::*;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pair
    pair_t p;
    assign p        = rails_i[2*g +: 2];
    assign vld_o[g] = p[1] | p[0];        // R2: either rail marks the bit valid
    assign bit_o[g] = p[1];               // R1: upper rail carries logic 1
    assign bad_o[g] = (p == PAIR_BAD);
  end
endmodule

// File: rtl/dr_celement.sv
module dr_celement #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] vld_i,
  output logic             done_o
);
  logic all_set, all_clear, done_q;

  assign all_set   = &vld_i;
  assign all_clear = ~|vld_i;

  always_ff @(posedge clk) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (all_set)   done_q <= 1'b1;
    else if (all_clear) done_q <= 1'b0;
  end

  assign done_o = done_q;

  a_r3_rise_after_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(&vld_i));
  a_r4_fall_after_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(~|vld_i));
  a_r5_hold_when_mixed: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld_i && !(&vld_i)) |=> $stable(done_q));
endmodule

// File: rtl/dr_completion_rx.sv
module dr_completion_rx #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*WIDTH-1:0] rails_i,
  output logic               ack_o,
  output logic [WIDTH-1:0]   word_o,
  output logic               word_valid_o,
  output logic               err_o
);
  logic [WIDTH-1:0] vld, bits, bad;
  logic             done;
  logic             rise;
  logic [WIDTH-1:0] word_q;
  logic             wv_q, err_q;

  dr_pair_decode #(.WIDTH(WIDTH)) u_dec (
    .rails_i(rails_i), .vld_o(vld), .bit_o(bits), .bad_o(bad)
  );

  dr_celement #(.WIDTH(WIDTH)) u_cel (
    .clk(clk), .rst_n(rst_n), .vld_i(vld), .done_o(done)
  );

  assign rise = (&vld) & ~done;   // completion about to set at this edge

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      wv_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wv_q  <= rise;
      if (rise) word_q <= bits;
      err_q <= err_q | (|bad);
    end
  end

  assign ack_o        = done;
  assign word_o       = word_q;
  assign word_valid_o = wv_q;
  assign err_o        = err_q;

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |=> !wv_q);
  a_r6_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |-> done);
  a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wv_q |-> $stable(word_q));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: tb/tb_dr_completion_rx.sv
module tb_dr_completion_rx;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*W-1:0] rails = '0;
  logic ack, wv, err;
  logic [W-1:0] word;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dr_completion_rx #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .rails_i(rails),
    .ack_o(ack), .word_o(word), .word_valid_o(wv), .err_o(err)
  );

  function automatic logic [2*W-1:0] enc(input logic [W-1:0] v);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // rails change on the falling edge; outputs are read 1 ns after the rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [2*W-1:0] r);
    @(negedge clk); rails = r;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rails = '0;
    step(); step();
    @(negedge clk); rst_n = 1;
    #1;
  endtask

  task automatic t_reset();
    chk("R9 ack", ack, 0);
    chk("R9 word_valid", wv, 0);
    chk("R9 err", err, 0);
    chk("R9 word", word, 0);
  endtask

  task automatic t_full(input logic [W-1:0] v);
    drive(enc(v)); step();
    chk("R3 ack rise", ack, 1);
    chk("R6 strobe", wv, 1);
    chk("R1 R6 word", word, v);
    drive(enc(v)); step();
    chk("R6 strobe one cycle", wv, 0);
    chk("R5 ack held", ack, 1);
    drive('0); step();
    chk("R4 ack fall", ack, 0);
    chk("R7 word kept", word, v);
  endtask

  task automatic t_stagger(input logic [W-1:0] v);
    logic [2*W-1:0] r = '0;
    logic [2*W-1:0] e = enc(v);
    for (int i = 0; i < W; i++) begin
      r[2*i +: 2] = e[2*i +: 2];
      drive(r); step();
      if (i < W-1) begin
        chk("R2 R5 ack low while partial", ack, 0);
        chk("R5 no strobe while partial", wv, 0);
      end else begin
        chk("R3 ack after last bit", ack, 1);
        chk("R6 word after stagger", word, v);
      end
    end
    for (int i = 0; i < W; i++) begin
      r[2*i +: 2] = 2'b00;
      drive(r); step();
      chk("R6 no repeat strobe", wv, 0);
      chk("R7 word stable on return", word, v);
      if (i < W-1) chk("R4 R5 ack held while partial", ack, 1);
      else         chk("R4 ack low after all empty", ack, 0);
    end
  endtask

  task automatic t_illegal();
    logic [2*W-1:0] r = '0;
    r[7:6] = 2'b11;
    drive(r); step();
    chk("R8 err set", err, 1);
    chk("R2 illegal alone no ack", ack, 0);
    drive('0); step();
    chk("R8 err sticky", err, 1);
    t_full(8'h3C);
    chk("R8 err persists", err, 1);
    do_reset();
    chk("R9 err cleared", err, 0);
    chk("R9 word cleared", word, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_full(8'hA5);
    t_full(8'h00);
    t_full(8'hFF);
    t_stagger(8'h5A);
    t_illegal();
    t_full(8'h81);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule